// File: doc/BRIEF.md
# Hashed Page Table Group Searcher

This block finds the translation for a virtual page in a hashed page table held in memory. A request gives a segment identifier and a page index. The block hashes them into a primary group index and reads that group's eight 16-byte entries one at a time, comparing each entry as it arrives. If none of the eight entries matches, it searches a secondary group at the complementary hash. The result is either the first matching entry's real page number with its protection and storage attributes, or a page fault.

The table's location comes from a byte base address, and its size comes from an index mask. Both are configuration inputs and must stay stable while a search runs. Reads use a simple port: the block holds a request and an address until the memory acknowledges with the 128-bit entry. Only one read is outstanding at a time.

Top module: `htab_group_search`

## Requirements
- R1: After reset, `req_ready` is 1, and `rd_req` and `resp_valid` are both 0.
- R2: The primary index is `(req_vsid[15:0] ^ req_pidx) & cfg_mask`. Slot s of group g is read at byte address `cfg_base + g*128 + s*16`.
- R3: The secondary index is `~(req_vsid[15:0] ^ req_pidx) & cfg_mask`.
- R4: An entry matches only when all of these hold: bit 0 (valid) is 1; bits [36:2] equal `{req_vsid, req_pidx[15:5]}`; and bit 1 (hash ID) is 0 in the primary group or 1 in the secondary group.
- R5: Slots are read in ascending order 0 to 7. `rd_addr` holds steady while `rd_req` waits for `rd_ack`. The search stops at the first matching slot, so a lower slot wins over a higher one.
- R6: The secondary group is read only after all eight primary slots have missed.
- R7: When all 16 slots miss, the response has `resp_fault`=1 and `resp_secondary`=1.
- R8: On a hit, the response fields come from the matching entry. The real page number is bits [107:80], protection is [65:64], no-execute is [66], WIMG is [70:67], changed is [71] and referenced is [72]. `resp_secondary` shows which group hit.
- R9: `resp_valid` is high for one cycle. `req_ready` is low during a search, and a request presented then has no effect.
- R10: `resp_valid` rises in the cycle right after the edge that takes the final read acknowledge, and a request is accepted while `req_ready` is high; the next cycle raises `rd_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_base | input | 32 | Byte base address of the hash table |
| cfg_mask | input | 16 | Group-index mask that sets the table size |
| req_valid | input | 1 | Lookup request |
| req_ready | output | 1 | Idle and able to accept a request |
| req_vsid | input | 24 | Segment identifier of the virtual page |
| req_pidx | input | 16 | Page index within the segment |
| rd_req | output | 1 | Memory read request, held until acknowledged |
| rd_addr | output | 32 | Byte address of the entry being read |
| rd_ack | input | 1 | Read data valid, consumes the request |
| rd_data | input | 128 | Entry returned by memory |
| resp_valid | output | 1 | One-cycle result strobe |
| resp_fault | output | 1 | No translation found |
| resp_secondary | output | 1 | Hit came from the secondary group |
| resp_rpn | output | 28 | Real page number |
| resp_pp | output | 2 | Page protection bits |
| resp_nx | output | 1 | No-execute bit |
| resp_wimg | output | 4 | Storage control bits |
| resp_ref | output | 1 | Referenced bit |
| resp_chg | output | 1 | Changed bit |

## Verification
The bench plants entries whose tag matches the request but whose hash ID is wrong, or whose valid bit is clear. A design that ignores the hash ID or the valid bit would return those entries instead of moving on to the secondary group. It also plants two matches in one group and counts the reads issued, which exposes a design that prefers the later slot or keeps reading after a hit. Full-miss lookups must take exactly sixteen reads and then fault. Runs with a smaller mask and requests driven during a busy search catch a design that forgets to mask the complemented hash or that accepts work while it is busy.

// File: rtl/htab_pkg.sv
package htab_pkg;

    localparam int ENT_BITS    = 128;
    localparam int GROUP_SLOTS = 8;
    localparam int SLOT_W      = $clog2(GROUP_SLOTS);
    localparam int ENT_OFS_W   = $clog2(ENT_BITS / 8);

    // Entry field positions (decoded by the match stage)
    localparam int F_VALID   = 0;
    localparam int F_HID     = 1;
    localparam int F_TAG_LO  = 2;
    localparam int F_PP_LO   = 64;
    localparam int F_NX      = 66;
    localparam int F_WIMG_LO = 67;
    localparam int F_CHG     = 71;
    localparam int F_REF     = 72;
    localparam int F_RPN_LO  = 80;

    typedef enum logic {
        S_IDLE,
        S_READ
    } srch_state_e;

endpackage

// File: rtl/htab_hash.sv
module htab_hash #(
    parameter int HASH_W = 16
) (
    input  logic [HASH_W-1:0] seg_lo,
    input  logic [HASH_W-1:0] page_idx,
    input  logic [HASH_W-1:0] size_mask,
    output logic [HASH_W-1:0] pri_idx,
    output logic [HASH_W-1:0] sec_idx
);

    logic [HASH_W-1:0] raw_hash;

    always_comb begin
        raw_hash = seg_lo ^ page_idx;
        pri_idx  = raw_hash & size_mask;
        sec_idx  = ~raw_hash & size_mask;
    end

endmodule

// File: rtl/htab_entry_match.sv
module htab_entry_match
    import htab_pkg::*;
#(
    parameter int TAG_W = 35,
    parameter int RPN_W = 28
) (
    input  logic [ENT_BITS-1:0] entry,
    input  logic [TAG_W-1:0]    want_tag,
    input  logic                want_hid,
    output logic                hit,
    output logic [RPN_W-1:0]    rpn,
    output logic [1:0]          pp,
    output logic                nx,
    output logic [3:0]          wimg,
    output logic                ref_bit,
    output logic                chg_bit
);

    logic spare_bits;

    always_comb begin
        hit     = entry[F_VALID]
                  && (entry[F_HID] == want_hid)
                  && (entry[F_TAG_LO +: TAG_W] == want_tag);
        rpn     = entry[F_RPN_LO +: RPN_W];
        pp      = entry[F_PP_LO +: 2];
        nx      = entry[F_NX];
        wimg    = entry[F_WIMG_LO +: 4];
        ref_bit = entry[F_REF];
        chg_bit = entry[F_CHG];
    end

    // fields reserved for software and padding
    assign spare_bits = ^{entry[F_PP_LO-1:F_TAG_LO+TAG_W],
                          entry[F_RPN_LO-1:F_REF+1],
                          entry[ENT_BITS-1:F_RPN_LO+RPN_W]};

endmodule

// File: rtl/htab_group_search.sv
module htab_group_search
    import htab_pkg::*;
#(
    parameter int VSID_W    = 24,
    parameter int PIDX_W    = 16,
    parameter int HASH_W    = 16,
    parameter int ABBR_DROP = 5,
    parameter int ADDR_W    = 32,
    parameter int RPN_W     = 28
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   cfg_base,
    input  logic [HASH_W-1:0]   cfg_mask,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [VSID_W-1:0]   req_vsid,
    input  logic [PIDX_W-1:0]   req_pidx,
    output logic                rd_req,
    output logic [ADDR_W-1:0]   rd_addr,
    input  logic                rd_ack,
    input  logic [ENT_BITS-1:0] rd_data,
    output logic                resp_valid,
    output logic                resp_fault,
    output logic                resp_secondary,
    output logic [RPN_W-1:0]    resp_rpn,
    output logic [1:0]          resp_pp,
    output logic                resp_nx,
    output logic [3:0]          resp_wimg,
    output logic                resp_ref,
    output logic                resp_chg
);

    localparam int TAG_W     = VSID_W + PIDX_W - ABBR_DROP;
    localparam int LAST_SLOT = GROUP_SLOTS - 1;

    typedef struct packed {
        srch_state_e       st;
        logic              pass;
        logic [SLOT_W-1:0] slot;
        logic [HASH_W-1:0] pri_idx;
        logic [HASH_W-1:0] sec_idx;
        logic [TAG_W-1:0]  tag;
        logic              rvalid;
        logic              fault;
        logic              sec;
        logic [RPN_W-1:0]  rpn;
        logic [1:0]        pp;
        logic              nx;
        logic [3:0]        wimg;
        logic              refb;
        logic              chg;
    } srch_regs_t;

    srch_regs_t r_d, r_q;

    logic [HASH_W-1:0] hash_pri, hash_sec, cur_idx;
    logic              ent_hit;
    logic [RPN_W-1:0]  ent_rpn;
    logic [1:0]        ent_pp;
    logic              ent_nx;
    logic [3:0]        ent_wimg;
    logic              ent_ref, ent_chg;

    htab_hash #(.HASH_W(HASH_W)) hash_i (
        .seg_lo   (req_vsid[HASH_W-1:0]),
        .page_idx (req_pidx[HASH_W-1:0]),
        .size_mask(cfg_mask),
        .pri_idx  (hash_pri),
        .sec_idx  (hash_sec)
    );

    htab_entry_match #(.TAG_W(TAG_W), .RPN_W(RPN_W)) match_i (
        .entry   (rd_data),
        .want_tag(r_q.tag),
        .want_hid(r_q.pass),
        .hit     (ent_hit),
        .rpn     (ent_rpn),
        .pp      (ent_pp),
        .nx      (ent_nx),
        .wimg    (ent_wimg),
        .ref_bit (ent_ref),
        .chg_bit (ent_chg)
    );

    always_comb begin
        cur_idx = r_q.pass ? r_q.sec_idx : r_q.pri_idx;
        rd_req  = (r_q.st == S_READ);
        rd_addr = cfg_base
                  + ADDR_W'({cur_idx, r_q.slot, {ENT_OFS_W{1'b0}}});
        req_ready = (r_q.st == S_IDLE);
    end

    always_comb begin
        r_d        = r_q;
        r_d.rvalid = 1'b0;
        case (r_q.st)
            S_IDLE: begin
                if (req_valid) begin
                    r_d.st      = S_READ;
                    r_d.pass    = 1'b0;
                    r_d.slot    = '0;
                    r_d.pri_idx = hash_pri;
                    r_d.sec_idx = hash_sec;
                    r_d.tag     = {req_vsid, req_pidx[PIDX_W-1:ABBR_DROP]};
                end
            end
            S_READ: begin
                if (rd_ack) begin
                    if (ent_hit) begin
                        r_d.st     = S_IDLE;
                        r_d.rvalid = 1'b1;
                        r_d.fault  = 1'b0;
                        r_d.sec    = r_q.pass;
                        r_d.rpn    = ent_rpn;
                        r_d.pp     = ent_pp;
                        r_d.nx     = ent_nx;
                        r_d.wimg   = ent_wimg;
                        r_d.refb   = ent_ref;
                        r_d.chg    = ent_chg;
                    end else if (r_q.slot != SLOT_W'(LAST_SLOT)) begin
                        r_d.slot = r_q.slot + 1'b1;
                    end else if (!r_q.pass) begin
                        r_d.pass = 1'b1;
                        r_d.slot = '0;
                    end else begin
                        r_d.st     = S_IDLE;
                        r_d.rvalid = 1'b1;
                        r_d.fault  = 1'b1;
                        r_d.sec    = 1'b1;
                        r_d.rpn    = '0;
                        r_d.pp     = '0;
                        r_d.nx     = 1'b0;
                        r_d.wimg   = '0;
                        r_d.refb   = 1'b0;
                        r_d.chg    = 1'b0;
                    end
                end
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign resp_valid     = r_q.rvalid;
    assign resp_fault     = r_q.fault;
    assign resp_secondary = r_q.sec;
    assign resp_rpn       = r_q.rpn;
    assign resp_pp        = r_q.pp;
    assign resp_nx        = r_q.nx;
    assign resp_wimg      = r_q.wimg;
    assign resp_ref       = r_q.refb;
    assign resp_chg       = r_q.chg;

    // R5
    rd_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && !rd_ack |=> rd_req && $stable(rd_addr));

    // R9
    resp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    // R9
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> !req_ready);

    // R10
    accept_to_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> rd_req);

    // R10
    hit_to_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && rd_ack && ent_hit |=> resp_valid && !resp_fault);

endmodule

// File: tb/htab_group_search_tb_top.sv
module htab_group_search_tb_top;

    localparam logic [31:0] BASE    = 32'h0004_0000;
    localparam int          MEM_ENT = 512;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [31:0]  cfg_base = BASE;
    logic [15:0]  cfg_mask = 16'h003F;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [23:0]  req_vsid = '0;
    logic [15:0]  req_pidx = '0;
    logic         rd_req;
    logic [31:0]  rd_addr;
    logic         rd_ack = 1'b0;
    logic [127:0] rd_data = '0;
    logic         resp_valid, resp_fault, resp_secondary;
    logic [27:0]  resp_rpn;
    logic [1:0]   resp_pp;
    logic         resp_nx;
    logic [3:0]   resp_wimg;
    logic         resp_ref, resp_chg;

    htab_group_search dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_mask(cfg_mask),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_vsid(req_vsid), .req_pidx(req_pidx),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
        .resp_valid(resp_valid), .resp_fault(resp_fault),
        .resp_secondary(resp_secondary), .resp_rpn(resp_rpn),
        .resp_pp(resp_pp), .resp_nx(resp_nx), .resp_wimg(resp_wimg),
        .resp_ref(resp_ref), .resp_chg(resp_chg)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int n_reads = 0;
    int last_ack_cyc = 0;
    int wait_cnt = 0;
    logic [127:0] mem [0:MEM_ENT-1];
    logic [31:0]  rd_log [0:31];
    logic [31:0]  exp_addr [0:15];
    int           n_exp;

    always @(posedge clk) cyc <= cyc + 1;

    // memory responder: variable latency, one acknowledge per read
    always @(negedge clk) begin
        if (rst_n) begin
            if (rd_ack) begin
                rd_ack = 1'b0;
            end else if (rd_req) begin
                if (wait_cnt == 0) begin
                    rd_data = mem[((rd_addr - BASE) >> 4) & (MEM_ENT - 1)];
                    rd_ack  = 1'b1;
                    if (n_reads < 32) rd_log[n_reads] = rd_addr;
                    n_reads++;
                    last_ack_cyc = cyc;
                    wait_cnt = $urandom_range(0, 2);
                end else begin
                    wait_cnt--;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [34:0] tag_of(input logic [23:0] v, input logic [15:0] p);
        return {v, p[15:5]};
    endfunction

    function automatic logic [127:0] mk_ent(input bit v, input bit h, input logic [34:0] tg,
                                            input logic [27:0] rpn, input logic [1:0] pp,
                                            input bit nx, input logic [3:0] wimg,
                                            input bit r, input bit c);
        logic [127:0] e = '0;
        e[0] = v; e[1] = h; e[36:2] = tg;
        e[65:64] = pp; e[66] = nx; e[70:67] = wimg; e[71] = c; e[72] = r;
        e[107:80] = rpn;
        return e;
    endfunction

    function automatic logic [127:0] rand_ent();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    task automatic scramble();
        for (int i = 0; i < MEM_ENT; i++) mem[i] = rand_ent();
    endtask

    // independent model: expected read sequence and result
    task automatic model(input logic [23:0] v, input logic [15:0] p, input logic [15:0] m,
                         output bit fault, output bit sec, output logic [127:0] ent);
        logic [15:0] h = v[15:0] ^ p;
        logic [15:0] idx;
        fault = 1'b1; sec = 1'b1; ent = '0; n_exp = 0;
        for (int ps = 0; ps < 2; ps++) begin
            idx = (ps == 0) ? (h & m) : (~h & m);
            for (int s = 0; s < 8; s++) begin
                logic [127:0] e = mem[idx * 8 + s];
                exp_addr[n_exp] = BASE + 32'(idx) * 128 + 32'(s) * 16;
                n_exp++;
                if (e[0] && e[1] == ps[0] && e[36:2] == tag_of(v, p)) begin
                    fault = 1'b0; sec = ps[0]; ent = e;
                    return;
                end
            end
        end
    endtask

    function automatic logic [15:0] pidx_of(input logic [15:0] m, input logic [23:0] v,
                                            input logic [15:0] grp, input logic [10:0] hi);
        // page index whose primary hash lands in group grp (bits above mask kept from hi)
        logic [15:0] p = {hi, 5'b0};
        return (p & ~m) | ((grp ^ v[15:0]) & m);
    endfunction

    task automatic lookup(input logic [23:0] v, input logic [15:0] p, input logic [15:0] m,
                          input bit noise, input string req);
        bit ef, es;
        logic [127:0] ee;
        int t;
        model(v, p, m, ef, es, ee);
        cfg_mask = m;
        @(negedge clk);
        n_reads = 0;
        req_valid = 1'b1; req_vsid = v; req_pidx = p;
        @(negedge clk);
        if (noise) begin
            req_vsid = ~v; req_pidx = ~p;
            chk(req_ready == 1'b0, "R9", "ready while busy", 64'(req_ready), 64'd0);
            @(negedge clk);
        end
        req_valid = 1'b0;
        t = 0;
        while (!resp_valid && t < 400) begin
            @(negedge clk);
            t++;
        end
        if (!resp_valid) begin
            chk(1'b0, req, "response timeout", 64'd0, 64'd1);
            return;
        end
        chk(cyc == last_ack_cyc + 1, "R10", "resp latency", 64'(cyc), 64'(last_ack_cyc + 1));
        chk(resp_fault == ef, ef ? "R7" : req, "fault", 64'(resp_fault), 64'(ef));
        chk(resp_secondary == es, "R6", "secondary flag", 64'(resp_secondary), 64'(es));
        if (!ef) begin
            chk({resp_rpn, resp_pp, resp_nx, resp_wimg, resp_ref, resp_chg} ==
                {ee[107:80], ee[65:64], ee[66], ee[70:67], ee[72], ee[71]},
                "R8", "fields",
                64'({resp_rpn, resp_pp, resp_nx, resp_wimg, resp_ref, resp_chg}),
                64'({ee[107:80], ee[65:64], ee[66], ee[70:67], ee[72], ee[71]}));
        end
        chk(n_reads == n_exp, "R5", "read count", 64'(n_reads), 64'(n_exp));
        for (int i = 0; i < n_exp && i < n_reads; i++) begin
            if (rd_log[i] != exp_addr[i])
                chk(1'b0, i < 8 ? "R2" : "R3", "read address", 64'(rd_log[i]), 64'(exp_addr[i]));
        end
        @(negedge clk);
        chk(resp_valid == 1'b0, "R9", "resp one cycle", 64'(resp_valid), 64'd0);
        chk(req_ready == 1'b1, "R9", "ready after resp", 64'(req_ready), 64'd1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [23:0] v;
        logic [15:0] p, pri, sec;
        process::self().srandom(32'h5EED_0042);
        scramble();
        repeat (3) @(negedge clk);
        // R1
        chk(req_ready == 1'b1, "R1", "reset ready", 64'(req_ready), 64'd1);
        chk(rd_req == 1'b0, "R1", "reset rd_req", 64'(rd_req), 64'd0);
        chk(resp_valid == 1'b0, "R1", "reset resp", 64'(resp_valid), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4: hit in primary slot 0
        v = 24'hA1B2C3; p = 16'h1234;
        pri = (v[15:0] ^ p) & 16'h3F;
        mem[pri * 8 + 0] = mk_ent(1, 0, tag_of(v, p), 28'hABCDEF1, 2'b10, 1, 4'h5, 1, 0);
        lookup(v, p, 16'h003F, 1'b0, "R4");

        // R9: same hit with a second request driven while busy
        lookup(v, p, 16'h003F, 1'b1, "R9");

        // R6 R4: primary full of wrong-H and invalid copies, hit in secondary slot 7
        scramble();
        v = 24'h0F00F0; p = 16'h8765;
        pri = (v[15:0] ^ p) & 16'h3F;
        sec = ~(v[15:0] ^ p) & 16'h3F;
        for (int s = 0; s < 8; s++)
            mem[pri * 8 + s] = mk_ent(s != 3, s == 3 ? 0 : 1, tag_of(v, p), 28'h1, 2'b11, 0, 4'hF, 1, 1);
        for (int s = 0; s < 7; s++)
            mem[sec * 8 + s] = mk_ent(1, 0, tag_of(v, p), 28'h2, 2'b00, 0, 4'h0, 0, 0);
        mem[sec * 8 + 7] = mk_ent(1, 1, tag_of(v, p), 28'h7654321, 2'b01, 0, 4'h9, 0, 1);
        lookup(v, p, 16'h003F, 1'b0, "R6");

        // R5: two matches in primary, lower slot wins
        scramble();
        v = 24'h123456; p = 16'hFEDC;
        pri = (v[15:0] ^ p) & 16'h3F;
        mem[pri * 8 + 5] = mk_ent(1, 0, tag_of(v, p), 28'h5555555, 2'b01, 1, 4'h1, 0, 1);
        mem[pri * 8 + 2] = mk_ent(1, 0, tag_of(v, p), 28'h2222222, 2'b10, 0, 4'h2, 1, 0);
        lookup(v, p, 16'h003F, 1'b0, "R5");

        // R7: full miss
        scramble();
        lookup(24'h777777, 16'h0101, 16'h003F, 1'b0, "R7");

        // R2 R3: smaller table, hit in secondary
        v = 24'h00BEEF; p = 16'h4321;
        sec = ~(v[15:0] ^ p) & 16'h000F;
        mem[sec * 8 + 4] = mk_ent(1, 1, tag_of(v, p), 28'h0C0FFEE, 2'b11, 1, 4'hA, 1, 1);
        lookup(v, p, 16'h000F, 1'b0, "R3");

        // constrained random mix
        for (int it = 0; it < 150; it++) begin
            int mode = $urandom_range(0, 3);
            logic [15:0] m = ($urandom_range(0, 1) == 0) ? 16'h003F : 16'h001F;
            scramble();
            v = 24'($urandom);
            p = pidx_of(m, v, 16'($urandom_range(0, 63)), 11'($urandom));
            pri = (v[15:0] ^ p) & m;
            sec = ~(v[15:0] ^ p) & m;
            case (mode)
                0: mem[pri * 8 + $urandom_range(0, 7)] =
                       mk_ent(1, 0, tag_of(v, p), 28'($urandom), 2'($urandom), 1'($urandom),
                              4'($urandom), 1'($urandom), 1'($urandom));
                1: mem[sec * 8 + $urandom_range(0, 7)] =
                       mk_ent(1, 1, tag_of(v, p), 28'($urandom), 2'($urandom), 1'($urandom),
                              4'($urandom), 1'($urandom), 1'($urandom));
                2: begin
                    mem[pri * 8 + $urandom_range(0, 7)] = mk_ent(1, 1, tag_of(v, p), 28'h3, 2'b01, 0, 4'h3, 0, 0);
                    mem[sec * 8 + $urandom_range(0, 7)] = mk_ent(1, 0, tag_of(v, p), 28'h4, 2'b10, 0, 4'h4, 0, 0);
                    mem[pri * 8 + $urandom_range(0, 7)] = mk_ent(0, 0, tag_of(v, p), 28'h5, 2'b11, 0, 4'h5, 0, 0);
                end
                default: ;
            endcase
            lookup(v, p, m, 1'($urandom_range(0, 1)), "R4");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule